// File: doc/BRIEF.md
# Line-Buffered 3x3 Image Convolver

This block filters a raster-scan image stream with a 3x3 kernel. One 8-bit pixel is accepted on every clock edge at which hold is low. Two on-chip line delays, whose length is programmed at run time up to `MAX_ROW` pixels, keep the two preceding image rows. Together with a 3x3 window register they supply nine pixels to nine multipliers. The nine products are summed into a 20-bit result. Window columns that fall past the left or right image edge count as zero.

Two complete coefficient sets are held in registers. A per-pixel bank-select input picks the set applied to each window, so the filter can change on any clock with no gap. Coefficients, the row length and the signedness mode are written through a small strobe-driven port made of an address, a data word, and active-low select and load lines. The port samples these strobes on the block clock, and a write takes effect when either strobe is released.

Top module: `conv3_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state after that edge: `res_out` is 0 and `res_valid` is 0.
- R2: After reset or a row-length write, pixel index n (counted from 0) produces a valid result only when n >= 2L+1, where L is the row length. While `res_valid` is low, `res_out` is 0.
- R3: The result is the sum of nine products, pixel times coefficient, where the window tap at row r (0 = oldest row) and column c (0 = left) uses coefficient r*3+c. The sum is centred on pixel n-L-1. It is given in 20 bits and never overflows, including 9 x 255 x 255.
- R4: When the centre pixel is in column 0, the left window column counts as zero. When the centre pixel is in column L-1, the right window column counts as zero.
- R5: A write to address 2 sets L = data[9:0]+1. The same write restarts the stream, so the next accepted pixel is index 0 and the output returns to 0 with `res_valid` low. After reset, L = MAX_ROW.
- R6: A write to address 0 with data[4:0] < 18 sets the coefficient pointer. Each write to address 1 stores data[7:0] at the pointer and then advances it, wrapping from 17 to 0. Entry b*9+t is bank b, tap t.
- R7: The `bank_sel` value sampled with pixel n picks the coefficient bank used for the result of pixel n, so the bank can change between consecutive pixels.
- R8: A write to address 3 sets the mode. Bit 0 = 1 treats pixels as two's complement, and bit 1 = 1 treats coefficients as two's complement. Otherwise values are unsigned.
- R9: While `hold` is high, no pixel is taken, and `res_out` and `res_valid` keep their values. After hold is released, the stream continues as if the hold had not occurred.
- R10: A configuration write commits at the first edge where `cfg_cs_n` or `cfg_ld_n` is seen high after an edge that saw both low. It uses the address and data sampled while both were low. Toggling one strobe while the other stays high writes nothing.
- R11: The result for the pixel taken at a rising edge appears at the next rising edge at which `hold` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Pixel in raster order |
| hold | input | 1 | Freeze pipeline and output |
| bank_sel | input | 1 | Coefficient bank for this pixel |
| cfg_addr | input | 3 | Configuration register address |
| cfg_data | input | 10 | Configuration write data |
| cfg_cs_n | input | 1 | Active-low configuration select |
| cfg_ld_n | input | 1 | Active-low configuration load |
| res_out | output | 20 | Convolution result |
| res_valid | output | 1 | Result valid |

## Verification
The assertions assume the configuration strobes are slow, synchronous signals: each phase of a write lasts at least one full clock, and the row length changes only through its register, which restarts the pipeline on the same edge. The bench drives every input on the falling edge and holds each strobe phase for a whole clock. It makes all configuration writes with `hold` high, so no pixel is taken while a write lands. Each stream starts with a row-length write, so the pixel count the checks depend on always begins at zero.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int RES_W   = 20;
    localparam int TAPS    = 9;
    localparam int BANKS   = 2;
    localparam int NCOEF   = BANKS * TAPS;
    localparam int CPTR_W  = $clog2(NCOEF);
    localparam int ADDR_W  = 3;
    localparam int CDATA_W = 10;
    localparam int PROD_W  = PIX_W + COEF_W + 2;
    localparam int ACC_W   = PROD_W + $clog2(TAPS);

    typedef enum logic [ADDR_W-1:0] {
        CFG_CPTR   = 3'd0,
        CFG_CDATA  = 3'd1,
        CFG_ROWLEN = 3'd2,
        CFG_MODE   = 3'd3
    } cfg_addr_e;

    typedef struct packed {
        logic coef_signed;
        logic pix_signed;
    } mode_t;

    typedef logic [TAPS-1:0][PIX_W-1:0]               window_t;
    typedef logic [BANKS-1:0][TAPS-1:0][COEF_W-1:0]   coef_set_t;

    function automatic logic signed [PIX_W:0] ext_pix(input logic [PIX_W-1:0] v, input logic sgn);
        return $signed({sgn & v[PIX_W-1], v});
    endfunction

    function automatic logic signed [COEF_W:0] ext_coef(input logic [COEF_W-1:0] v, input logic sgn);
        return $signed({sgn & v[COEF_W-1], v});
    endfunction

endpackage

// File: rtl/conv3_cfg.sv
module conv3_cfg
    import conv3_pkg::*;
#(
    parameter int MAX_ROW = 1024,
    parameter int LEN_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CDATA_W-1:0]  cfg_data,
    input  logic                cfg_cs_n,
    input  logic                cfg_ld_n,
    output coef_set_t           coefs,
    output logic [LEN_W-1:0]    len_m1,
    output mode_t               mode,
    output logic                restart
);

    logic                   strobe, armed, commit;
    logic [ADDR_W-1:0]      addr_q;
    logic [CDATA_W-1:0]     data_q;
    logic [CPTR_W-1:0]      cptr;
    logic [NCOEF-1:0][COEF_W-1:0] coef_q;

    assign strobe  = ~cfg_cs_n & ~cfg_ld_n;
    assign commit  = armed & ~strobe;
    assign restart = commit && (cfg_addr_e'(addr_q) == CFG_ROWLEN);
    assign coefs   = coef_set_t'(coef_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            armed <= strobe;
            if (strobe) begin
                addr_q <= cfg_addr;
                data_q <= cfg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
            cptr   <= '0;
            len_m1 <= LEN_W'(MAX_ROW - 1);
            mode   <= '0;
        end else if (commit) begin
            case (cfg_addr_e'(addr_q))
                CFG_CPTR: begin
                    if (data_q[CPTR_W-1:0] < CPTR_W'(NCOEF))
                        cptr <= data_q[CPTR_W-1:0];
                end
                CFG_CDATA: begin
                    coef_q[cptr] <= data_q[COEF_W-1:0];
                    cptr <= (cptr == CPTR_W'(NCOEF - 1)) ? '0 : cptr + 1'b1;
                end
                CFG_ROWLEN: len_m1 <= data_q[LEN_W-1:0];
                CFG_MODE:   mode   <= mode_t'(data_q[1:0]);
                default: ;
            endcase
        end
    end

    // R10: a commit needs a fresh strobe, so two commits never sit back to back
    p_commit_gap_r10: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R6: coefficient pointer stays inside the two banks
    p_cptr_range_r6: assert property (@(posedge clk) disable iff (rst)
        cptr < CPTR_W'(NCOEF));

endmodule

// File: rtl/conv3_linebuf.sv
module conv3_linebuf
    import conv3_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              adv,
    input  logic [AW-1:0]     len_m1,
    input  logic [PIX_W-1:0]  din,
    output logic [PIX_W-1:0]  dout
);

    logic [PIX_W-1:0] mem [DEPTH];
    logic [AW-1:0]    ptr;

    assign dout = mem[ptr];

    always_ff @(posedge clk) begin
        if (adv) mem[ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)  ptr <= '0;
        else if (adv)        ptr <= (ptr == len_m1) ? '0 : ptr + 1'b1;
    end

    // R5: the delay pointer never runs past the programmed row length
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (rst)
        ptr <= len_m1);

endmodule

// File: rtl/conv3_window.sv
module conv3_window
    import conv3_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              adv,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic [PIX_W-1:0]  row1_in,
    input  logic [PIX_W-1:0]  row2_in,
    input  logic              bank_in,
    output window_t           win,
    output logic              bank_q,
    output logic              win_valid
);

    localparam int FILL_W = LEN_W + 2;

    logic [2:0][2:0][PIX_W-1:0] wr;
    logic [LEN_W-1:0]  in_col, ccol;
    logic [FILL_W-1:0] fill, thr;

    assign thr = {FILL_W'(len_m1), 1'b0} + FILL_W'(3);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wr        <= '0;
            in_col    <= '0;
            ccol      <= '0;
            fill      <= '0;
            bank_q    <= 1'b0;
            win_valid <= 1'b0;
        end else if (adv) begin
            for (int r = 0; r < 3; r++) begin
                wr[r][0] <= wr[r][1];
                wr[r][1] <= wr[r][2];
            end
            wr[0][2]  <= row2_in;
            wr[1][2]  <= row1_in;
            wr[2][2]  <= pix_in;
            in_col    <= (in_col == len_m1) ? '0 : in_col + 1'b1;
            ccol      <= (in_col == '0) ? len_m1 : in_col - 1'b1;
            bank_q    <= bank_in;
            win_valid <= (fill >= thr);
            if (fill < thr) fill <= fill + 1'b1;
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            logic edge_out;
            if (c == 0)      begin : g_l assign edge_out = (ccol == '0);    end
            else if (c == 2) begin : g_r assign edge_out = (ccol == len_m1); end
            else             begin : g_m assign edge_out = 1'b0;            end
            assign win[r*3+c] = edge_out ? '0 : wr[r][c];
        end
    end

    // R4: the centre column index stays inside the programmed row
    p_ccol_range_r4: assert property (@(posedge clk) disable iff (rst)
        ccol <= len_m1);

endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
    import conv3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             adv,
    input  window_t          win,
    input  logic             win_valid,
    input  logic             bank_q,
    input  coef_set_t        coefs,
    input  mode_t            mode,
    output logic [RES_W-1:0] res_out,
    output logic             res_valid
);

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  sum;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign prod[t] = ext_pix(win[t], mode.pix_signed)
                       * ext_coef(coefs[bank_q][t], mode.coef_signed);
    end

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) sum = sum + ACC_W'(prod[t]);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            res_out   <= '0;
            res_valid <= 1'b0;
        end else if (adv) begin
            res_valid <= win_valid;
            res_out   <= win_valid ? sum[RES_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/conv3_top.sv
module conv3_top
    import conv3_pkg::*;
#(
    parameter int MAX_ROW = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   pix_in,
    input  logic         hold,
    input  logic         bank_sel,
    input  logic [2:0]   cfg_addr,
    input  logic [9:0]   cfg_data,
    input  logic         cfg_cs_n,
    input  logic         cfg_ld_n,
    output logic [19:0]  res_out,
    output logic         res_valid
);

    localparam int LEN_W = $clog2(MAX_ROW);
    localparam int NLINE = 2;

    coef_set_t           coefs;
    mode_t               mode;
    logic [LEN_W-1:0]    len_m1;
    logic                restart, adv;
    logic [PIX_W-1:0]    row_tap [NLINE+1];
    window_t             win;
    logic                bank_q, win_valid;

    assign adv        = ~hold & ~restart;
    assign row_tap[0] = pix_in;

    conv3_cfg #(.MAX_ROW(MAX_ROW), .LEN_W(LEN_W)) cfg_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_cs_n(cfg_cs_n), .cfg_ld_n(cfg_ld_n), .coefs(coefs),
        .len_m1(len_m1), .mode(mode), .restart(restart)
    );

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        conv3_linebuf #(.DEPTH(MAX_ROW), .AW(LEN_W)) line_i (
            .clk(clk), .rst(rst), .restart(restart), .adv(adv),
            .len_m1(len_m1), .din(row_tap[g]), .dout(row_tap[g+1])
        );
    end

    conv3_window #(.LEN_W(LEN_W)) win_i (
        .clk(clk), .rst(rst), .restart(restart), .adv(adv), .len_m1(len_m1),
        .pix_in(pix_in), .row1_in(row_tap[1]), .row2_in(row_tap[2]),
        .bank_in(bank_sel), .win(win), .bank_q(bank_q), .win_valid(win_valid)
    );

    conv3_mac mac_i (
        .clk(clk), .rst(rst), .restart(restart), .adv(adv), .win(win),
        .win_valid(win_valid), .bank_q(bank_q), .coefs(coefs), .mode(mode),
        .res_out(res_out), .res_valid(res_valid)
    );

    // R1: reset leaves the output cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res_out == '0 && !res_valid));

    // R9: hold freezes the output
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (hold && !restart) |=> ($stable(res_out) && $stable(res_valid)));

    // R2: once valid, the output stays valid until a restart
    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !restart) |=> res_valid);

endmodule

// File: tb/conv3_top_tb_top.sv
module conv3_top_tb_top;

    localparam int NV = 20;
    // bit 8 = bank select, bits 7:0 = pixel
    localparam logic [8:0] VEC [NV] = '{
        9'h003, 9'h120, 9'h07F, 9'h180, 9'h0FF, 9'h005, 9'h1C8, 9'h040, 9'h011, 9'h1FE,
        9'h090, 9'h033, 9'h1AA, 9'h000, 9'h055, 9'h17E, 9'h081, 9'h0E0, 9'h109, 9'h0C3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix_in = '0;
    logic        hold = 1'b0;
    logic        bank_sel = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [9:0]  cfg_data = '0;
    logic        cfg_cs_n = 1'b1;
    logic        cfg_ld_n = 1'b1;
    logic [19:0] res_out;
    logic        res_valid;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int row_len, psgn, csgn;
    int img [64];
    int bnk [64];
    int cf [2][9];

    always #5 clk = ~clk;

    conv3_top dut_i (
        .clk(clk), .rst(rst), .pix_in(pix_in), .hold(hold), .bank_sel(bank_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_cs_n(cfg_cs_n),
        .cfg_ld_n(cfg_ld_n), .res_out(res_out), .res_valid(res_valid)
    );

    function automatic int sx(input int v, input int sgn);
        return (sgn != 0 && v > 127) ? v - 256 : v;
    endfunction

    function automatic int model(input int n);
        int c, cy, cx, s;
        c = n - row_len - 1; cy = c / row_len; cx = c % row_len; s = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (cx + dc >= 0 && cx + dc < row_len)
                    s += sx(img[(cy+dr)*row_len + cx + dc], psgn)
                       * sx(cf[bnk[n]][(dr+1)*3 + dc + 1], csgn);
        return s & 32'hFFFFF;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_result(input int n, input string extra);
        bit ev; int ex, cx;
        ev = (n >= 2*row_len + 1);
        ex = ev ? model(n) : 0;
        cx = (n - row_len - 1) % row_len;
        if (!ev)                                    check({"R2 ", extra}, {res_valid, res_out}, {1'b0, 20'h0});
        else if (cx == 0 || cx == row_len - 1)      check({"R4 R11 ", extra}, {res_valid, res_out}, {1'b1, ex[19:0]});
        else                                        check({"R3 R7 R11 ", extra}, {res_valid, res_out}, {1'b1, ex[19:0]});
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk); cfg_addr = 3'(a); cfg_data = 10'(d); cfg_cs_n = 0; cfg_ld_n = 0;
        @(negedge clk); cfg_ld_n = 1;
        @(negedge clk); cfg_cs_n = 1; cfg_addr = '0; cfg_data = '0;
    endtask

    task automatic load_coefs();
        cfg_write(0, 0);
        for (int b = 0; b < 2; b++)
            for (int t = 0; t < 9; t++) cfg_write(1, cf[b][t]);
    endtask

    task automatic restart_len(input int l);
        row_len = l;
        cfg_write(2, l - 1);
        check("R5 restart", {res_valid, res_out}, {1'b0, 20'h0});
    endtask

    task automatic stream(input int n, input int hold_idx, input int hold_len, input string extra);
        for (int i = 0; i <= n; i++) begin
            pix_in   = (i < n) ? 8'(img[i]) : 8'h5A;
            bank_sel = (i < n) ? bnk[i][0] : 1'b0;
            hold     = 0;
            @(negedge clk);
            if (i >= 1) chk_result(i - 1, extra);
            if (i == hold_idx) begin
                hold = 1; pix_in = 8'hEE; bank_sel = ~bank_sel;
                for (int k = 0; k < hold_len; k++) begin
                    @(negedge clk);
                    chk_result(i - 1, "R9");
                end
            end
        end
        hold = 1;
    endtask

    task automatic use_table();
        for (int i = 0; i < NV; i++) begin
            img[i] = int'(VEC[i][7:0]);
            bnk[i] = int'(VEC[i][8]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cf[0] = '{1, 2, 1, 2, 4, 2, 1, 2, 1};
        cf[1] = '{255, 0, 1, 254, 0, 2, 255, 7, 1};
        psgn = 0; csgn = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", {res_valid, res_out}, {1'b0, 20'h0});
        rst = 0;
        hold = 1;
        @(negedge clk);
        check("R1 after reset", {res_valid, res_out}, {1'b0, 20'h0});

        // R6 R7 R9 R3 R4: unsigned, banks switched per pixel, hold mid-stream
        load_coefs();
        cfg_write(3, 0);
        restart_len(4);
        use_table();
        stream(NV, 11, 3, "unsigned");

        // R8: both operands signed
        cfg_write(3, 3);
        psgn = 1; csgn = 1;
        restart_len(4);
        stream(NV, 4, 2, "R8 signed");

        // R8: signed pixels, unsigned coefficients, row length 5
        cfg_write(3, 1);
        psgn = 1; csgn = 0;
        restart_len(5);
        stream(NV, -1, 0, "R8 mixed");

        // R10: single-strobe toggles must not change the row length
        cfg_write(3, 0);
        psgn = 0; csgn = 0;
        restart_len(4);
        @(negedge clk); cfg_addr = 3'd2; cfg_data = 10'd1; cfg_cs_n = 0;
        @(negedge clk); cfg_cs_n = 1; cfg_ld_n = 0;
        @(negedge clk); cfg_ld_n = 1; cfg_addr = '0; cfg_data = '0;
        @(negedge clk);
        stream(NV, -1, 0, "R10");

        // R3: largest unsigned magnitude, row length 3
        for (int t = 0; t < 9; t++) begin cf[0][t] = 255; cf[1][t] = 255; end
        load_coefs();
        for (int i = 0; i < 12; i++) begin img[i] = 255; bnk[i] = i % 2; end
        restart_len(3);
        stream(12, -1, 0, "R3 max");

        // R1: reset in mid-stream clears the output
        rst = 1;
        @(negedge clk);
        check("R1 mid reset", {res_valid, res_out}, {1'b0, 20'h0});
        rst = 0;

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule